// File: doc/BRIEF.md
# USB Bus Condition Timer

This block watches the decoded line state of a full-speed USB function and turns timed bus conditions into sticky interrupt status. A single-ended-zero that lasts long enough flags a bus reset. A long idle (J) period flags suspend and moves the block into a low-power sequence. A start-of-frame pulse from the packet decoder is recorded as well. Software enables each cause on its own and clears status by writing ones. A single interrupt line is raised while any enabled cause is pending.

Once suspended, the block can shut off the oscillator after a programmable delay. A remote-wakeup request made during suspend is held back until the bus has been idle for the minimum time. The block then restarts the oscillator and drives the resume (K) state for a fixed time before it returns to normal operation.

All time limits are given as cycle counts at 12 MHz. A frequency-select input halves every limit when the block runs from a 6 MHz clock, so every count parameter must be even.

Top module: `usb_bus_mon`

## Requirements
- R1: After reset, all three status bits are 0, the interrupt is low, the oscillator enable is 1 and the resume drive is 0.
- R2: Line encoding: 00 is SE0, 01 is J (idle), 10 is K, and 11 counts as activity. A run of consecutive SE0 samples that reaches RST_CYC sets status bit 1 on the edge that samples the RST_CYC-th SE0. A shorter run does not set it. Each run sets it only once, so clearing the bit while SE0 continues leaves it clear.
- R3: A run of consecutive J samples that reaches SUSP_CYC sets status bit 2 and enters suspend. Any non-J sample restarts the run.
- R4: A one-cycle sof_i pulse sets status bit 0 at the following edge.
- R5: Status bits are sticky until a 1 is written to the matching bit of int_clr_i. A set in the same cycle wins over a clear. irq_o is the OR of status ANDed bit by bit with int_en_i.
- R6: With fast_clk_i = 0, every limit is half of its 12 MHz value.
- R7: With osc_stop_en_i = 1, osc_en_o falls OSCOFF_CYC cycles after the edge that enters suspend.
- R8: With osc_stop_en_i = 0, osc_en_o stays 1 during suspend.
- R9: A wake request during suspend is held until the current J run reaches WAKE_CYC. On that edge osc_en_o and resume_k_o go to 1. If the run has already reached WAKE_CYC, this happens on the edge that samples the request.
- R10: resume_k_o stays high for exactly RESUME_CYC cycles, and the block then returns to active. The idle run is held at zero during resume, so a new suspend needs a full SUSP_CYC of J after resume ends.
- R11: A wake request made outside suspend is ignored and does not start resume later.
- R12: Any non-J sample during suspend returns the block to active, turns the oscillator back on and cancels a held wake request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (6 or 12 MHz) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_state_i | input | 2 | Decoded line state, synchronous to clk_i |
| sof_i | input | 1 | Start-of-frame detected pulse |
| fast_clk_i | input | 1 | 1: 12 MHz limits, 0: 6 MHz limits |
| int_en_i | input | 3 | Interrupt enables {suspend, reset, sof} |
| int_clr_i | input | 3 | Write-one-to-clear pulses for status |
| osc_stop_en_i | input | 1 | Allow the oscillator to stop during suspend |
| wake_req_i | input | 1 | Remote-wakeup request pulse |
| status_o | output | 3 | Sticky status {suspend, reset, sof} |
| irq_o | output | 1 | Interrupt request, active high |
| osc_en_o | output | 1 | Oscillator enable |
| resume_k_o | output | 1 | Drive K onto the bus for resume |

## Verification
The assertions assume that line_state_i is already synchronized to clk_i and that int_clr_i and sof_i are cycle-wide values sampled at the same edge as the line. The stimulus meets this by changing every input shortly after a rising edge and holding it until the next one. It drives SE1 only as a form of activity and never asserts wake_req_i during its random phase, so the only route into resume is the directed sequences. Random segment lengths cluster just below and just above the reset and suspend limits, so the run counters are exercised across both boundaries.

// File: rtl/usb_bus_mon_pkg.sv
`timescale 1ns/1ps
package usb_bus_mon_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  typedef enum logic [1:0] {
    PS_ACTIVE,
    PS_SUSPEND,
    PS_SLEEP,
    PS_RESUME
  } pwr_e;

  localparam int ST_SOF = 0;
  localparam int ST_RST = 1;
  localparam int ST_SUSP = 2;
  localparam int ST_W = 3;
endpackage

// File: rtl/usb_run_timer.sv
`timescale 1ns/1ps
// Counts consecutive cycles of a condition, saturating at MAX_CNT.
module usb_run_timer #(
  parameter int MAX_CNT = 30,
  localparam int CW = $clog2(MAX_CNT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic          restart_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] SAT = CW'(MAX_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (restart_i || !hit_i) cnt_o <= '0;
    else if (cnt_o != SAT) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/usb_sticky_status.sv
`timescale 1ns/1ps
module usb_sticky_status #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] stat_o,
  output logic         irq_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_o[b] <= 1'b0;
      else if (set_i[b]) stat_o[b] <= 1'b1;  // set beats clear
      else if (clr_i[b]) stat_o[b] <= 1'b0;
    end
  end

  assign irq_o = |(stat_o & en_i);
endmodule

// File: rtl/usb_pwr_seq.sv
`timescale 1ns/1ps
module usb_pwr_seq
  import usb_bus_mon_pkg::*;
#(
  parameter int TMR_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             susp_hit_i,
  input  logic             line_idle_i,
  input  logic             wake_ok_i,
  input  logic             wake_req_i,
  input  logic             osc_stop_en_i,
  input  logic [TMR_W-1:0] osc_lim_i,
  input  logic [TMR_W-1:0] res_lim_i,
  output logic             osc_en_o,
  output logic             resume_k_o,
  output logic             idle_restart_o
);
  pwr_e             state_q;
  logic [TMR_W-1:0] tmr_q;
  logic             pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_ACTIVE;
      tmr_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      case (state_q)
        PS_ACTIVE: begin
          pend_q <= 1'b0;
          if (susp_hit_i) begin
            state_q <= PS_SUSPEND;
            tmr_q   <= '0;
          end
        end
        PS_SUSPEND, PS_SLEEP: begin
          if (!line_idle_i) begin
            state_q <= PS_ACTIVE;
            pend_q  <= 1'b0;
          end else if ((pend_q || wake_req_i) && wake_ok_i) begin
            state_q <= PS_RESUME;
            tmr_q   <= '0;
            pend_q  <= 1'b0;
          end else begin
            pend_q <= pend_q | wake_req_i;
            if (state_q == PS_SUSPEND) begin
              if (osc_stop_en_i && (tmr_q >= osc_lim_i)) state_q <= PS_SLEEP;
              else if (tmr_q != '1) tmr_q <= tmr_q + 1'b1;
            end
          end
        end
        PS_RESUME: begin
          if (tmr_q == res_lim_i) state_q <= PS_ACTIVE;
          else tmr_q <= tmr_q + 1'b1;
        end
        default: state_q <= PS_ACTIVE;
      endcase
    end
  end

  assign osc_en_o       = (state_q != PS_SLEEP);
  assign resume_k_o     = (state_q == PS_RESUME);
  assign idle_restart_o = (state_q == PS_RESUME);
endmodule

// File: rtl/usb_bus_mon.sv
`timescale 1ns/1ps
module usb_bus_mon
  import usb_bus_mon_pkg::*;
#(
  parameter int RST_CYC    = 30,      // 2.5 us at 12 MHz
  parameter int SUSP_CYC   = 36000,   // 3 ms
  parameter int OSCOFF_CYC = 24000,   // 2 ms
  parameter int WAKE_CYC   = 60000,   // 5 ms
  parameter int RESUME_CYC = 120000   // 10 ms
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      line_state_i,
  input  logic            sof_i,
  input  logic            fast_clk_i,
  input  logic [ST_W-1:0] int_en_i,
  input  logic [ST_W-1:0] int_clr_i,
  input  logic            osc_stop_en_i,
  input  logic            wake_req_i,
  output logic [ST_W-1:0] status_o,
  output logic            irq_o,
  output logic            osc_en_o,
  output logic            resume_k_o
);
  localparam int IDLE_MAX = (SUSP_CYC > WAKE_CYC) ? SUSP_CYC : WAKE_CYC;
  localparam int TMR_MAX  = (OSCOFF_CYC > RESUME_CYC) ? OSCOFF_CYC : RESUME_CYC;
  localparam int SE0_W    = $clog2(RST_CYC + 1);
  localparam int IDLE_W   = $clog2(IDLE_MAX + 1);
  localparam int TMR_W    = $clog2(TMR_MAX + 1);

  logic              is_se0, is_j;
  logic [SE0_W-1:0]  se0_cnt, rst_lim;
  logic [IDLE_W-1:0] idle_cnt, susp_lim, wake_lim;
  logic [TMR_W-1:0]  osc_lim, res_lim;
  logic              se0_hit, susp_hit, wake_ok, idle_restart;
  logic [ST_W-1:0]   set_vec;

  assign is_se0 = (line_state_i == LS_SE0);
  assign is_j   = (line_state_i == LS_J);

  // Limits minus one: compared against the count before this sample.
  assign rst_lim  = fast_clk_i ? SE0_W'(RST_CYC - 1)     : SE0_W'(RST_CYC / 2 - 1);
  assign susp_lim = fast_clk_i ? IDLE_W'(SUSP_CYC - 1)   : IDLE_W'(SUSP_CYC / 2 - 1);
  assign wake_lim = fast_clk_i ? IDLE_W'(WAKE_CYC - 1)   : IDLE_W'(WAKE_CYC / 2 - 1);
  assign osc_lim  = fast_clk_i ? TMR_W'(OSCOFF_CYC - 1)  : TMR_W'(OSCOFF_CYC / 2 - 1);
  assign res_lim  = fast_clk_i ? TMR_W'(RESUME_CYC - 1)  : TMR_W'(RESUME_CYC / 2 - 1);

  usb_run_timer #(.MAX_CNT(RST_CYC)) u_se0_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (is_se0),
    .restart_i(1'b0),
    .cnt_o    (se0_cnt)
  );

  usb_run_timer #(.MAX_CNT(IDLE_MAX)) u_idle_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (is_j),
    .restart_i(idle_restart),
    .cnt_o    (idle_cnt)
  );

  // Exact match fires once per run; the saturated count never matches again.
  assign se0_hit  = is_se0 && (se0_cnt == rst_lim);
  assign susp_hit = is_j && (idle_cnt == susp_lim);
  assign wake_ok  = is_j && (idle_cnt >= wake_lim);

  always_comb begin
    set_vec          = '0;
    set_vec[ST_SOF]  = sof_i;
    set_vec[ST_RST]  = se0_hit;
    set_vec[ST_SUSP] = susp_hit;
  end

  usb_sticky_status #(.N(ST_W)) u_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (int_clr_i),
    .en_i  (int_en_i),
    .stat_o(status_o),
    .irq_o (irq_o)
  );

  usb_pwr_seq #(.TMR_W(TMR_W)) u_pwr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .susp_hit_i    (susp_hit),
    .line_idle_i   (is_j),
    .wake_ok_i     (wake_ok),
    .wake_req_i    (wake_req_i),
    .osc_stop_en_i (osc_stop_en_i),
    .osc_lim_i     (osc_lim),
    .res_lim_i     (res_lim),
    .osc_en_o      (osc_en_o),
    .resume_k_o    (resume_k_o),
    .idle_restart_o(idle_restart)
  );
endmodule

// File: rtl/usb_bus_mon_chk.sv
`timescale 1ns/1ps
module usb_bus_mon_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] line_state_i,
  input logic       sof_i,
  input logic [2:0] int_en_i,
  input logic [2:0] int_clr_i,
  input logic       osc_stop_en_i,
  input logic [2:0] status_o,
  input logic       irq_o,
  input logic       osc_en_o,
  input logic       resume_k_o
);
  assert_sof_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> status_o[0]);

  assert_rst_from_se0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> $past(line_state_i) == 2'b00);

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_clr_i[1] && line_state_i != 2'b00) |=> !status_o[1]);

  assert_irq_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o & int_en_i) != 3'b000);

  assert_resume_osc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_k_o |-> osc_en_o);

  assert_resume_from_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resume_k_o) |-> $past(line_state_i) == 2'b01);

  assert_osc_stop_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> $past(osc_stop_en_i));
endmodule

bind usb_bus_mon usb_bus_mon_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_state_i (line_state_i),
  .sof_i        (sof_i),
  .int_en_i     (int_en_i),
  .int_clr_i    (int_clr_i),
  .osc_stop_en_i(osc_stop_en_i),
  .status_o     (status_o),
  .irq_o        (irq_o),
  .osc_en_o     (osc_en_o),
  .resume_k_o   (resume_k_o)
);

// File: tb/usb_bus_mon_tb_top.sv
`timescale 1ns/1ps
module usb_bus_mon_tb_top;
  localparam int RST_C  = 30;
  localparam int SUSP_C = 400;
  localparam int OSC_C  = 150;
  localparam int WAKE_C = 600;
  localparam int RES_C  = 1000;
  localparam logic [1:0] L_SE0 = 2'b00, L_J = 2'b01, L_K = 2'b10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] line = L_K;
  logic       sof = 1'b0, fast = 1'b1, osc_stop = 1'b0, wake = 1'b0;
  logic [2:0] en = 3'b000, clr = 3'b000;
  logic [2:0] status;
  logic       irq, osc_en, resume_k;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  usb_bus_mon #(
    .RST_CYC(RST_C), .SUSP_CYC(SUSP_C), .OSCOFF_CYC(OSC_C),
    .WAKE_CYC(WAKE_C), .RESUME_CYC(RES_C)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_state_i(line), .sof_i(sof),
    .fast_clk_i(fast), .int_en_i(en), .int_clr_i(clr),
    .osc_stop_en_i(osc_stop), .wake_req_i(wake),
    .status_o(status), .irq_o(irq), .osc_en_o(osc_en), .resume_k_o(resume_k)
  );

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic [1:0] ls, input int n);
    line = ls;
    repeat (n) tick();
  endtask

  task automatic clear(input logic [2:0] m);
    clr = m;
    tick();
    clr = 3'b000;
  endtask

  task automatic wake_pulse();
    wake = 1'b1;
    tick();
    wake = 1'b0;
  endtask

  function automatic logic [2:0] next_stat(input logic [2:0] cur, input logic [2:0] set,
                                           input logic [2:0] c);
    return set | (cur & ~c);
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int se0_run, idle_run, len;
    logic [1:0] sym;
    logic [2:0] exp_st, set_v;
    void'($urandom(32'd5150));

    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    check("R1 status", status, 0);
    check("R1 irq", irq, 0);
    check("R1 osc_en", osc_en, 1);
    check("R1 resume", resume_k, 0);

    en = 3'b111;
    // R2 reset limit and once-per-run
    hold(L_SE0, RST_C - 1);
    check("R2 below limit", status[1], 0);
    hold(L_SE0, 1);
    check("R2 at limit", status[1], 1);
    check("R5 irq on reset", irq, 1);
    hold(L_SE0, 5);
    clear(3'b010);
    check("R2 cleared during run", status[1], 0);
    hold(L_SE0, 40);
    check("R2 no re-set same run", status[1], 0);
    hold(L_K, 1);

    // R6 halved limits
    fast = 1'b0;
    hold(L_SE0, RST_C / 2 - 1);
    check("R6 reset below half", status[1], 0);
    hold(L_SE0, 1);
    check("R6 reset at half", status[1], 1);
    hold(L_K, 1);
    clear(3'b010);
    hold(L_J, SUSP_C / 2 - 1);
    check("R6 suspend below half", status[2], 0);
    hold(L_J, 1);
    check("R6 suspend at half", status[2], 1);
    hold(L_K, 1);
    clear(3'b100);
    fast = 1'b1;

    // R4 / R5 sof, set beats clear, masking
    sof = 1'b1; tick(); sof = 1'b0;
    check("R4 sof set", status[0], 1);
    sof = 1'b1; clr = 3'b001; tick(); sof = 1'b0; clr = 3'b000;
    check("R5 set wins over clear", status[0], 1);
    en = 3'b110; tick();
    check("R5 masked irq", irq, 0);
    en = 3'b111; tick();
    check("R5 enabled irq", irq, 1);
    clear(3'b001);
    check("R5 w1c", status[0], 0);
    check("R5 irq drop", irq, 0);

    // R3 suspend, run restart; R8 osc kept
    hold(L_J, SUSP_C - 1);
    check("R3 below limit", status[2], 0);
    hold(L_K, 1);
    hold(L_J, SUSP_C - 1);
    check("R3 run restarted", status[2], 0);
    hold(L_J, 1);
    check("R3 at limit", status[2], 1);
    hold(L_J, 300);
    check("R8 osc stays on", osc_en, 1);
    hold(L_K, 1);
    check("R12 active after K", osc_en, 1);
    clear(3'b100);

    // R7 oscillator stop delay
    osc_stop = 1'b1;
    hold(L_J, SUSP_C);
    check("R7 suspend entered", status[2], 1);
    hold(L_J, OSC_C - 1);
    check("R7 osc before delay", osc_en, 1);
    hold(L_J, 1);
    check("R7 osc stopped", osc_en, 0);
    hold(L_K, 1);
    check("R12 osc restarts on K", osc_en, 1);
    clear(3'b100);

    // R9 deferred wakeup, R10 resume length and idle restart
    hold(L_J, SUSP_C);
    line = L_J;
    wake_pulse();
    hold(L_J, WAKE_C - SUSP_C - 2);
    check("R9 held before idle limit", resume_k, 0);
    check("R7 asleep while held", osc_en, 0);
    hold(L_J, 1);
    check("R9 resume at idle limit", resume_k, 1);
    check("R9 osc restarted", osc_en, 1);
    hold(L_J, RES_C - 1);
    check("R10 resume still on", resume_k, 1);
    hold(L_J, 1);
    check("R10 resume ends", resume_k, 0);
    clear(3'b100);
    hold(L_J, SUSP_C - 2);
    check("R10 idle restarted", status[2], 0);
    hold(L_J, 1);
    check("R10 suspend after full run", status[2], 1);
    osc_stop = 1'b0;
    hold(L_K, 1);
    clear(3'b100);

    // R9 idle already long enough
    hold(L_J, WAKE_C + 50);
    wake_pulse();
    check("R9 immediate resume", resume_k, 1);
    hold(L_J, RES_C);
    check("R10 resume ends (immediate)", resume_k, 0);
    hold(L_K, 1);
    clear(3'b100);

    // R11 wake while active ignored
    wake_pulse();
    hold(L_J, WAKE_C + 50);
    check("R11 active wake ignored", resume_k, 0);
    hold(L_K, 1);
    clear(3'b100);

    // R12 activity cancels held wake
    hold(L_J, SUSP_C + 20);
    wake_pulse();
    hold(L_J, 29);
    hold(L_K, 1);
    check("R12 active after K", resume_k, 0);
    hold(L_J, WAKE_C + 50);
    check("R12 held wake cancelled", resume_k, 0);
    hold(L_K, 1);
    clear(3'b111);

    // random phase checked against a requirement model
    exp_st = 3'b000;
    se0_run = 0;
    idle_run = 0;
    for (int s = 0; s < 250; s++) begin
      sym = 2'($urandom % 4);
      len = $urandom % 8;
      if (len == 0) len = SUSP_C - 4 + int'($urandom % 9);
      else if (len < 3) len = RST_C - 3 + int'($urandom % 7);
      else len = 1 + int'($urandom % 6);
      for (int c = 0; c < len; c++) begin
        line = sym;
        sof = ($urandom % 16 == 0);
        clr = ($urandom % 12 == 0) ? 3'($urandom) : 3'b000;
        if ($urandom % 20 == 0) en = 3'($urandom);
        se0_run = (sym == L_SE0) ? se0_run + 1 : 0;
        idle_run = (sym == L_J) ? idle_run + 1 : 0;
        set_v = {idle_run == SUSP_C, se0_run == RST_C, sof};
        exp_st = next_stat(exp_st, set_v, clr);
        tick();
        check("R4 rand sof", status[0], exp_st[0]);
        check("R2 rand reset", status[1], exp_st[1]);
        check("R3 rand suspend", status[2], exp_st[2]);
        check("R5 rand irq", irq, |(exp_st & en));
      end
    end
    sof = 1'b0;
    clr = 3'b000;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule